// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This block sits between a host register port and a byte-wide external EEPROM. The host uses it in two ways. It can move one byte at a time between a data register and any EEPROM location. It can also start a burst that walks the EEPROM in sequence, packs the bytes into records and writes each record into internal memory through a generic write port.

A burst record is four bytes taken in EEPROM order: target offset low, target offset high, data low, data high. The 24-bit memory address is built from a 9-bit base held in a register and the low 15 bits of the record's offset. The top bit of the offset is dropped. A burst ends in one of two ways: an offset of 0xFFFF marks the end of the table, or a programmed number of records has been written. A burst starts at EEPROM address 0 when nothing has been accessed since reset. Otherwise it continues from the byte after the last one the block accessed.

Request bits clear themselves when their access completes, so the host polls them. While any access runs, the block reports busy and drops every host write.

Top module: `eeprom_burst_ctrl`

## Requirements
- R1: Writing the control register (index 0) with bit 1 set while idle starts a single read. The read uses the address register (index 1). When the EEPROM acknowledges, the data register (index 2) takes the returned byte.
- R2: Writing the control register with bit 0 set and bit 1 clear while idle starts a single write of the data register's byte to the address register's location. If bits 0 and 1 are both set, the block performs a read.
- R3: Control bit 1 reads 1 while a single read is outstanding, and bit 0 reads 1 while a single write is outstanding. The bit reads 0 from the clock edge that accepts the acknowledge, and from that point the data register holds the read byte.
- R4: Writing bit 0 of the burst register (index 3) while idle starts a burst. That bit reads 1 while the burst runs and 0 after it ends. Every register reads 0 after reset.
- R5: If no EEPROM access has been acknowledged since reset, a burst fetches its first byte from address 0. Otherwise the first byte comes from the address after the last acknowledged access, whether that access was a single access or part of a burst. The address wraps at 16 bits.
- R6: Each burst record is four consecutive bytes (offset low, offset high, data low, data high). In the cycle after the fourth byte is acknowledged, the block emits exactly one one-cycle memory write with address {base register (index 4), offset[14:0]} and data {data high, data low}.
- R7: A burst stops after the offset-high byte when the offset is 0xFFFF. In that case it does not fetch the record's data bytes and writes nothing to memory. A burst also stops after as many records as the limit register (index 5) holds. A burst started with a limit of 0 makes no EEPROM access.
- R8: Control bit 2 reads 1 while a single access or a burst is in progress. Host writes to any register are ignored during that time.
- R9: The EEPROM request stays high, with address, direction and write byte unchanged, until it is acknowledged. Each acknowledge completes exactly one byte.
- R10: The address register holds 16 bits, the data register 8 bits, the base register 9 bits and the limit register 8 bits. Each reads back zero-extended, and indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Host register index |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for reg_addr (combinational) |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | EEPROM direction, 1 = write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM acknowledge, one cycle per byte |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 16 | Memory write data |

## Verification
Errors in the resume pointer show up on ee_addr at the first request of the next burst. Errors in the record byte index or the record counter show up within one record: as a mem_we in the wrong cycle, a wrong mem_addr or mem_wdata, or the burst bit clearing at the wrong edge. Because the reference model is compared against every port on every clock, including read-back of a different register index each cycle, a dropped busy gate or a request bit that fails to clear is reported in the first cycle it diverges.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_SINGLE = 2'd1,
    ENG_BURST  = 2'd2
  } eng_state_t;

  // Host register indices
  localparam int REG_CTRL  = 0;
  localparam int REG_ADDR  = 1;
  localparam int REG_DATA  = 2;
  localparam int REG_BURST = 3;
  localparam int REG_BASE  = 4;
  localparam int REG_LIMIT = 5;

  // Control register bit positions
  localparam int CTL_WR_BIT   = 0;
  localparam int CTL_RD_BIT   = 1;
  localparam int CTL_BUSY_BIT = 2;

  // Byte positions inside a burst record
  localparam logic [1:0] REC_OFS_LO = 2'd0;
  localparam logic [1:0] REC_OFS_HI = 2'd1;
  localparam logic [1:0] REC_DAT_LO = 2'd2;
  localparam logic [1:0] REC_DAT_HI = 2'd3;
endpackage

// File: rtl/eeb_rst_sync.sv
module eeb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/eeb_regs.sv
module eeb_regs
  import eeb_pkg::*;
#(
  parameter int EE_AW   = 16,
  parameter int HOST_DW = 16,
  parameter int REG_AW  = 3,
  parameter int BASE_W  = 9,
  parameter int LIM_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [HOST_DW-1:0] reg_wdata,
  output logic [HOST_DW-1:0] reg_rdata,
  input  eng_state_t         eng_state,
  input  logic               eng_we,
  input  logic               rd_done,
  input  logic [7:0]         rd_byte,
  output logic               go_single,
  output logic               go_we,
  output logic               go_burst,
  output logic [EE_AW-1:0]   addr_q,
  output logic [7:0]         data_q,
  output logic [BASE_W-1:0]  base_q,
  output logic [LIM_W-1:0]   limit_q
);
  logic busy;
  logic wr_ok;
  logic hit_ctrl, hit_addr, hit_data, hit_burst, hit_base, hit_limit;
  logic [EE_AW-1:0]  addr_d;
  logic [7:0]        data_d;
  logic [BASE_W-1:0] base_d;
  logic [LIM_W-1:0]  limit_d;
  logic              addr_en, data_en, base_en, limit_en;

  assign busy  = (eng_state != ENG_IDLE);
  assign wr_ok = reg_wr && !busy;

  assign hit_ctrl  = (reg_addr == REG_AW'(REG_CTRL));
  assign hit_addr  = (reg_addr == REG_AW'(REG_ADDR));
  assign hit_data  = (reg_addr == REG_AW'(REG_DATA));
  assign hit_burst = (reg_addr == REG_AW'(REG_BURST));
  assign hit_base  = (reg_addr == REG_AW'(REG_BASE));
  assign hit_limit = (reg_addr == REG_AW'(REG_LIMIT));

  // Command decode: read wins when both request bits are written
  assign go_single = wr_ok && hit_ctrl && (reg_wdata[CTL_RD_BIT] || reg_wdata[CTL_WR_BIT]);
  assign go_we     = !reg_wdata[CTL_RD_BIT];
  assign go_burst  = wr_ok && hit_burst && reg_wdata[0];

  // Next-state and clock enables
  always_comb begin
    addr_en  = wr_ok && hit_addr;
    base_en  = wr_ok && hit_base;
    limit_en = wr_ok && hit_limit;
    data_en  = rd_done || (wr_ok && hit_data);
    addr_d   = reg_wdata[EE_AW-1:0];
    base_d   = reg_wdata[BASE_W-1:0];
    limit_d  = reg_wdata[LIM_W-1:0];
    data_d   = rd_done ? rd_byte : reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (addr_en)  addr_q  <= addr_d;
      if (data_en)  data_q  <= data_d;
      if (base_en)  base_q  <= base_d;
      if (limit_en) limit_q <= limit_d;
    end
  end

  // Read-back mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_AW'(REG_CTRL): begin
        reg_rdata[CTL_WR_BIT]   = (eng_state == ENG_SINGLE) && eng_we;
        reg_rdata[CTL_RD_BIT]   = (eng_state == ENG_SINGLE) && !eng_we;
        reg_rdata[CTL_BUSY_BIT] = busy;
      end
      REG_AW'(REG_ADDR):  reg_rdata[EE_AW-1:0]  = addr_q;
      REG_AW'(REG_DATA):  reg_rdata[7:0]        = data_q;
      REG_AW'(REG_BURST): reg_rdata[0]          = (eng_state == ENG_BURST);
      REG_AW'(REG_BASE):  reg_rdata[BASE_W-1:0] = base_q;
      REG_AW'(REG_LIMIT): reg_rdata[LIM_W-1:0]  = limit_q;
      default:            reg_rdata             = '0;
    endcase
  end

  // R8: configuration does not move while an access is running
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> ($stable(addr_q) && $stable(base_q) && $stable(limit_q)));

  // R1: a completed single read changes the data register only through rd_byte
  a_r1_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done) |=> $stable(data_q));
endmodule

// File: rtl/eeb_engine.sv
module eeb_engine
  import eeb_pkg::*;
#(
  parameter int EE_AW = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_single,
  input  logic             go_we,
  input  logic             go_burst,
  input  logic [EE_AW-1:0] addr_q,
  input  logic [LIM_W-1:0] limit_q,
  input  logic             end_mark,
  input  logic             ee_ack,
  output logic             ee_req,
  output logic             ee_we,
  output logic [EE_AW-1:0] ee_addr,
  output eng_state_t       state_q,
  output logic             we_q,
  output logic [1:0]       idx_q,
  output logic             byte_take,
  output logic             rec_done,
  output logic             rd_done
);
  eng_state_t       state_d;
  logic             we_d;
  logic [1:0]       idx_d;
  logic [EE_AW-1:0] ptr_q, ptr_d;
  logic [LIM_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             accept;

  assign ee_req    = (state_q != ENG_IDLE);
  assign ee_we     = (state_q == ENG_SINGLE) && we_q;
  assign ee_addr   = (state_q == ENG_SINGLE) ? addr_q : ptr_q;
  assign accept    = ee_req && ee_ack;
  assign byte_take = accept && (state_q == ENG_BURST);
  assign rec_done  = byte_take && (idx_q == REC_DAT_HI);
  assign rd_done   = accept && (state_q == ENG_SINGLE) && !we_q;
  assign cnt_inc   = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    we_d    = we_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (go_single) begin
          state_d = ENG_SINGLE;
          we_d    = go_we;
        end else if (go_burst && (limit_q != '0)) begin
          state_d = ENG_BURST;
          idx_d   = REC_OFS_LO;
          cnt_d   = '0;
        end
      end
      ENG_SINGLE: begin
        if (accept) begin
          state_d = ENG_IDLE;
          ptr_d   = addr_q + 1'b1;
        end
      end
      ENG_BURST: begin
        if (accept) begin
          ptr_d = ptr_q + 1'b1;
          if ((idx_q == REC_OFS_HI) && end_mark) begin
            state_d = ENG_IDLE;
          end else if (idx_q == REC_DAT_HI) begin
            cnt_d = cnt_inc;
            idx_d = REC_OFS_LO;
            if (cnt_inc == limit_q) state_d = ENG_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      we_q    <= 1'b0;
      idx_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
    end
  end

  // R9: request attributes hold until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we)));

  // R7: the record count never reaches the limit while the burst is still running
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_BURST) |-> (cnt_q < limit_q));

  // R3: an acknowledged single access returns the engine to idle
  a_r3_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ENG_SINGLE) && ee_ack) |=> (state_q == ENG_IDLE));

  // R7: a burst request with a zero limit starts nothing
  a_r7_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ENG_IDLE) && go_burst && !go_single && (limit_q == '0)) |=> !ee_req);
endmodule

// File: rtl/eeb_rec_pack.sv
module eeb_rec_pack
  import eeb_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic [1:0]        idx_q,
  input  logic [7:0]        ee_rdata,
  input  logic              rec_done,
  input  logic [BASE_W-1:0] base_q,
  output logic              end_mark,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [15:0]       mem_wdata
);
  localparam int OFS_W = MEM_AW - BASE_W;
  localparam int HI_W  = OFS_W - 8;

  logic [7:0]        ofs_lo_q;
  logic [HI_W-1:0]   ofs_hi_q;
  logic [7:0]        dat_lo_q;
  logic              lo_en, hi_en, dl_en;
  logic              mem_we_d;
  logic [MEM_AW-1:0] mem_addr_d;
  logic [15:0]       mem_wdata_d;

  assign end_mark = (idx_q == REC_OFS_HI) && (&{ee_rdata, ofs_lo_q});

  always_comb begin
    lo_en       = byte_take && (idx_q == REC_OFS_LO);
    hi_en       = byte_take && (idx_q == REC_OFS_HI);
    dl_en       = byte_take && (idx_q == REC_DAT_LO);
    mem_we_d    = rec_done;
    mem_addr_d  = {base_q, ofs_hi_q, ofs_lo_q};
    mem_wdata_d = {ee_rdata, dat_lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_lo_q  <= '0;
      ofs_hi_q  <= '0;
      dat_lo_q  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      if (lo_en) ofs_lo_q <= ee_rdata;
      if (hi_en) ofs_hi_q <= ee_rdata[HI_W-1:0];
      if (dl_en) dat_lo_q <= ee_rdata;
      mem_we <= mem_we_d;
      if (rec_done) begin
        mem_addr  <= mem_addr_d;
        mem_wdata <= mem_wdata_d;
      end
    end
  end

  // R6: a record produces a single-cycle write strobe
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R6: the data-low byte is captured before the record completes
  a_r6_lo_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> !dl_en);
endmodule

// File: rtl/eeprom_burst_ctrl.sv
module eeprom_burst_ctrl
  import eeb_pkg::*;
#(
  parameter int EE_AW   = 16,
  parameter int HOST_DW = 16,
  parameter int REG_AW  = 3,
  parameter int MEM_AW  = 24,
  parameter int BASE_W  = 9,
  parameter int LIM_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [HOST_DW-1:0] reg_wdata,
  output logic [HOST_DW-1:0] reg_rdata,
  output logic               ee_req,
  output logic               ee_we,
  output logic [EE_AW-1:0]   ee_addr,
  output logic [7:0]         ee_wdata,
  input  logic               ee_ack,
  input  logic [7:0]         ee_rdata,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [15:0]        mem_wdata
);
  logic              rst_n_s;
  logic              go_single, go_we, go_burst;
  logic [EE_AW-1:0]  addr_q;
  logic [7:0]        data_q;
  logic [BASE_W-1:0] base_q;
  logic [LIM_W-1:0]  limit_q;
  eng_state_t        eng_state;
  logic              eng_we;
  logic [1:0]        idx_q;
  logic              byte_take, rec_done, rd_done, end_mark;

  eeb_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  eeb_regs #(
    .EE_AW(EE_AW), .HOST_DW(HOST_DW), .REG_AW(REG_AW), .BASE_W(BASE_W), .LIM_W(LIM_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_state (eng_state),
    .eng_we    (eng_we),
    .rd_done   (rd_done),
    .rd_byte   (ee_rdata),
    .go_single (go_single),
    .go_we     (go_we),
    .go_burst  (go_burst),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .base_q    (base_q),
    .limit_q   (limit_q)
  );

  eeb_engine #(.EE_AW(EE_AW), .LIM_W(LIM_W)) i_eng (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .go_single (go_single),
    .go_we     (go_we),
    .go_burst  (go_burst),
    .addr_q    (addr_q),
    .limit_q   (limit_q),
    .end_mark  (end_mark),
    .ee_ack    (ee_ack),
    .ee_req    (ee_req),
    .ee_we     (ee_we),
    .ee_addr   (ee_addr),
    .state_q   (eng_state),
    .we_q      (eng_we),
    .idx_q     (idx_q),
    .byte_take (byte_take),
    .rec_done  (rec_done),
    .rd_done   (rd_done)
  );

  eeb_rec_pack #(.MEM_AW(MEM_AW), .BASE_W(BASE_W)) i_pack (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .byte_take (byte_take),
    .idx_q     (idx_q),
    .ee_rdata  (ee_rdata),
    .rec_done  (rec_done),
    .base_q    (base_q),
    .end_mark  (end_mark),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign ee_wdata = data_q;

  // R2: write byte held stable during a pending write
  a_r2_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ee_req && ee_we && !ee_ack) |=> $stable(ee_wdata));
endmodule

// File: tb/test_eeprom_burst_ctrl.sv
module test_eeprom_burst_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ee_req, ee_we;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata;
  logic        ee_ack = 1'b0;
  logic [7:0]  ee_rdata = '0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata;

  eeprom_burst_ctrl i_eeprom_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req), .ee_we(ee_we),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit chk_on = 1'b0;

  // EEPROM behaviour
  logic [7:0] rom [0:65535];
  int ack_wait = 0;

  always @(negedge clk) begin
    if (ee_ack) begin
      ee_ack = 1'b0;
      ack_wait = 0;
    end else if (rst_n && ee_req) begin
      if (ack_wait >= int'(ee_addr[1:0])) begin
        ee_ack = 1'b1;
        if (ee_we) rom[ee_addr] = ee_wdata;
        else       ee_rdata = rom[ee_addr];
        ack_wait = 0;
      end else begin
        ack_wait++;
      end
    end
  end

  // Reference model: 0 idle, 1 single, 2 burst
  int         m_state = 0;
  bit         m_we = 0;
  logic [15:0] m_areg = '0;
  logic [7:0]  m_data = '0;
  logic [8:0]  m_base = '0;
  int          m_limit = 0;
  logic [15:0] m_ptr = '0;
  int          m_idx = 0;
  int          m_cnt = 0;
  logic [7:0]  m_b [4];
  bit          m_mwe = 0;
  logic [23:0] m_maddr = '0;
  logic [15:0] m_mdata = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_mwe = 1'b0;
      if (m_state == 1 && ee_ack) begin
        if (!m_we) m_data = ee_rdata;
        m_ptr = m_areg + 16'd1;
        m_state = 0;
      end else if (m_state == 2 && ee_ack) begin
        m_b[m_idx] = ee_rdata;
        m_ptr = m_ptr + 16'd1;
        if (m_idx == 1 && m_b[0] == 8'hFF && m_b[1] == 8'hFF) begin
          m_state = 0;
        end else if (m_idx == 3) begin
          m_mwe = 1'b1;
          m_maddr = {m_base, m_b[1][6:0], m_b[0]};
          m_mdata = {m_b[3], m_b[2]};
          m_cnt++;
          m_idx = 0;
          if (m_cnt == m_limit) m_state = 0;
        end else begin
          m_idx++;
        end
      end else if (m_state == 0 && reg_wr) begin
        case (reg_addr)
          3'd0: if (reg_wdata[1]) begin m_state = 1; m_we = 0; end
                else if (reg_wdata[0]) begin m_state = 1; m_we = 1; end
          3'd1: m_areg = reg_wdata;
          3'd2: m_data = reg_wdata[7:0];
          3'd3: if (reg_wdata[0] && m_limit != 0) begin m_state = 2; m_idx = 0; m_cnt = 0; end
          3'd4: m_base = reg_wdata[8:0];
          3'd5: m_limit = int'(reg_wdata[7:0]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_rdata(input logic [2:0] a);
    case (a)
      3'd0: return {13'd0, m_state != 0, m_state == 1 && !m_we, m_state == 1 && m_we};
      3'd1: return m_areg;
      3'd2: return {8'd0, m_data};
      3'd3: return {15'd0, m_state == 2};
      3'd4: return {7'd0, m_base};
      3'd5: return 16'(m_limit);
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  // Per-cycle comparison, a quarter period after each rising edge
  always @(posedge clk) begin
    cycles++;
    #(CLK_PERIOD/4);
    if (chk_on) begin
      case (reg_addr)
        3'd0:    check("R3 R8 control readback", 32'(reg_rdata), 32'(exp_rdata(reg_addr)));
        3'd2:    check("R1 data register", 32'(reg_rdata), 32'(exp_rdata(reg_addr)));
        3'd3:    check("R4 burst bit", 32'(reg_rdata), 32'(exp_rdata(reg_addr)));
        default: check("R10 register readback", 32'(reg_rdata), 32'(exp_rdata(reg_addr)));
      endcase
      check("R9 ee_req", 32'(ee_req), 32'(m_state != 0));
      if (m_state != 0) begin
        check("R5 R9 ee_addr", 32'(ee_addr), 32'(m_state == 1 ? m_areg : m_ptr));
        check("R2 ee_we", 32'(ee_we), 32'(m_state == 1 && m_we));
        check("R2 ee_wdata", 32'(ee_wdata), 32'(m_data));
      end
      check("R6 R7 mem_we", 32'(mem_we), 32'(m_mwe));
      if (m_mwe) begin
        check("R6 mem_addr", 32'(mem_addr), 32'(m_maddr));
        check("R6 mem_wdata", 32'(mem_wdata), 32'(m_mdata));
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      reg_addr = reg_addr + 3'd1;
      if (m_state == 0 && k > 2) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) rom[i] = 8'(i * 37 + 11);
    rom[1]    = 8'h81;             // offset MSB set, must be dropped (R6)
    rom[16'h45] = 8'hFF;           // end-of-table marker (R7)
    rom[16'h46] = 8'hFF;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;
    // R4 R10: reset values read back across all indices
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      reg_addr = 3'(a);
    end

    // R5: first burst after reset begins at 0; R7 limit of 3 records
    reg_write(3'd4, 16'h01A5);
    reg_write(3'd5, 16'd3);
    reg_write(3'd3, 16'h0001);
    wait_idle();

    // R2: single write, then R1: read it back
    reg_write(3'd1, 16'h0040);
    reg_write(3'd2, 16'h005A);
    reg_write(3'd0, 16'h0001);
    wait_idle();
    reg_write(3'd2, 16'h0000);
    reg_write(3'd0, 16'h0002);
    wait_idle();

    // R5: burst resumes after 0x40; R7 ends on 0xFFFF offset; R8 writes while busy dropped
    reg_write(3'd5, 16'd255);
    reg_write(3'd3, 16'h0001);
    reg_write(3'd0, 16'h0002);
    reg_write(3'd1, 16'h1234);
    reg_write(3'd5, 16'd1);
    reg_write(3'd4, 16'h0077);
    wait_idle();

    // R2: both request bits set performs a read
    reg_write(3'd1, 16'h1234);
    reg_write(3'd0, 16'h0003);
    wait_idle();

    // R7: zero limit starts nothing
    reg_write(3'd5, 16'd0);
    reg_write(3'd3, 16'h0001);
    wait_idle();

    // R5: burst after a single read resumes at 0x1235
    reg_write(3'd5, 16'd2);
    reg_write(3'd3, 16'h0001);
    wait_idle();

    // R5: wrap from 0xFFFF to 0
    reg_write(3'd1, 16'hFFFF);
    reg_write(3'd0, 16'h0002);
    wait_idle();
    reg_write(3'd5, 16'd1);
    reg_write(3'd3, 16'h0001);
    wait_idle();

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule